// File: doc/BRIEF.md
# USB Device Interrupt Source Decoder

This block gathers the interrupt causes of a USB device controller into a sticky flag word and produces one interrupt line from it. Each cause pulse on `evt_i` sets its flag. A flag stays set until software reads the matching status word, which the controller signals with a read-clear strobe and a flag index. An enable mask gates which pending flags count. A separate enable further gates the three endpoint 0 causes.

Beside the interrupt line, the block reports which pending cause should be serviced first. Control and bus causes come first, in a fixed order. Data endpoints 1 to 15 follow, and among them the lowest-numbered one wins. For a data endpoint the block also reports its number and its transfer kind. The kind comes from the endpoint number modulo 3. All inputs and outputs are plain control and status pins, so there is no handshake.

Top module: `usb_irq_decoder`

## Requirements
- R1: After reset, every flag and every mask bit is 0, the cause is none (code 0, endpoint 0, kind 0), and `irq_o` sits at its inactive level for the selected polarity.
- R2: A 1 on `evt_i[k]` for k in 1..22 sets flag k on the next clock edge. The flag stays set for as long as no read-clear targets it.
- R3: With `rd_clr_i` high and `rd_sel_i` = k, flag k is 0 after the edge, unless it is set again in the same cycle. An index of 23 or more clears nothing.
- R4: When a set and a read-clear hit the same flag in one cycle, the flag ends up set.
- R5: A flag is pending only while its bit in the enable mask is 1. The mask is loaded from `mask_data_i` on an edge where `mask_wr_i` is high.
- R6: Flags 1, 2 and 3 (setup, endpoint 0 IN, endpoint 0 OUT) count as pending only while `ep0_irq_en_i` is 1.
- R7: `irq_o` is 1 exactly when some flag is pending, if `irq_pol_hi_i` is 1. If `irq_pol_hi_i` is 0, `irq_o` is the inverse of that.
- R8: Among pending flags 1..7, the lowest bit wins. The cause code equals the bit number: 1 setup, 2 endpoint 0 IN, 3 endpoint 0 OUT, 4 bus reset, 5 resume, 6 suspend, 7 connect. Endpoint and kind are then 0.
- R9: Endpoint n (1..15) reports on flag bit n+7. It is decoded only when no flag 1..7 is pending. It then gives cause code 8, with `cause_ep_o` set to the lowest pending endpoint number.
- R10: The kind for endpoint n is 1 (bulk OUT) when n mod 3 = 1, 2 (bulk IN) when n mod 3 = 2, and 3 (interrupt IN) when n mod 3 = 0.
- R11: Flag bit 0 is reserved. It never sets, whatever `evt_i[0]` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 23 | Cause pulses, one per flag bit |
| rd_clr_i | input | 1 | Status read strobe, clears the selected flag |
| rd_sel_i | input | 5 | Flag index cleared by the read |
| mask_wr_i | input | 1 | Load strobe for the enable mask |
| mask_data_i | input | 23 | New enable mask value |
| irq_pol_hi_i | input | 1 | 1 = active-high interrupt line, 0 = active-low |
| ep0_irq_en_i | input | 1 | Enables the endpoint 0 causes (flags 1..3) |
| flags_o | output | 23 | Current sticky flag word |
| irq_o | output | 1 | Interrupt line |
| cause_o | output | 4 | Highest-priority pending cause code |
| cause_ep_o | output | 4 | Endpoint number for cause 8, else 0 |
| cause_xfer_o | output | 2 | Transfer kind for cause 8, else 0 |

## Verification
On every cycle, the assertions check these relations:
- a set beats a same-cycle clear;
- a read-clear empties its flag;
- the reserved bit stays 0;
- the line level matches the decode under the chosen polarity;
- a data-endpoint decode never hides a pending control or bus cause;
- the kind agrees with the endpoint number modulo 3;
- with the endpoint 0 enable off, no endpoint 0 cause is reported.

Other behaviour only the bench scenarios can show, because it depends on histories of writes and reads:
- a flag stays sticky across idle cycles;
- a masked flag becomes visible when its mask bit is turned on;
- an out-of-range read index clears nothing;
- the lowest pending endpoint is chosen;
- the priority order holds as causes are cleared one by one.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int CTRL_BITS = 8;   // bit 0 reserved, bits 1..7 control and bus causes

  typedef enum logic [3:0] {
    CAUSE_NONE    = 4'd0,
    CAUSE_SETUP   = 4'd1,
    CAUSE_EP0_IN  = 4'd2,
    CAUSE_EP0_OUT = 4'd3,
    CAUSE_BUS_RST = 4'd4,
    CAUSE_RESUME  = 4'd5,
    CAUSE_SUSPEND = 4'd6,
    CAUSE_CONNECT = 4'd7,
    CAUSE_DATA_EP = 4'd8
  } cause_e;

  typedef enum logic [1:0] {
    XK_NONE     = 2'd0,
    XK_BULK_OUT = 2'd1,
    XK_BULK_IN  = 2'd2,
    XK_INT_IN   = 2'd3
  } xfer_kind_e;

  function automatic xfer_kind_e kind_of_ep(input int n);
    case (n % 3)
      1:       return XK_BULK_OUT;
      2:       return XK_BULK_IN;
      default: return XK_INT_IN;
    endcase
  endfunction
endpackage

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int FLAG_W = 23,
  parameter int SEL_W  = $clog2(FLAG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              rd_clr_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] RSVD = FLAG_W'(1);

  logic [FLAG_W-1:0] flags_q, clr_vec, set_eff;

  always_comb begin
    clr_vec = '0;
    if (rd_clr_i && (int'(rd_sel_i) < FLAG_W)) clr_vec[rd_sel_i] = 1'b1;
  end

  assign set_eff = set_i & ~RSVD;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | set_eff;
  end

  assign flags_o = flags_q;

  // R4: a set in the same cycle as a clear leaves the flag set
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((flags_q & $past(set_eff)) == $past(set_eff)));

  // R3: a read-clear empties its flag when no set arrives with it
  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (int'(rd_sel_i) < FLAG_W) && ((set_i & clr_vec) == '0))
    |=> (((flags_q >> $past(rd_sel_i)) & FLAG_W'(1)) == '0));

  // R11: reserved bit never sets
  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (flags_q[0] == 1'b0));
endmodule

// File: rtl/usb_irq_prio.sv
module usb_irq_prio
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 15,
  parameter int EP_W   = 4,
  parameter int FLAG_W = CTRL_BITS + NUM_EP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] pend_i,
  output cause_e            cause_o,
  output logic [EP_W-1:0]   ep_o,
  output xfer_kind_e        kind_o
);
  xfer_kind_e kind_tbl [NUM_EP+1];

  assign kind_tbl[0] = XK_NONE;
  for (genvar g = 1; g <= NUM_EP; g++) begin : g_kind
    assign kind_tbl[g] = kind_of_ep(g);
  end

  always_comb begin
    cause_o = CAUSE_NONE;
    ep_o    = '0;
    kind_o  = XK_NONE;
    // scan high to low so the lowest pending endpoint is the last to win
    for (int n = NUM_EP; n >= 1; n--) begin
      if (pend_i[CTRL_BITS + n - 1]) begin
        cause_o = CAUSE_DATA_EP;
        ep_o    = EP_W'(n);
        kind_o  = kind_tbl[n];
      end
    end
    for (int b = CTRL_BITS - 1; b >= 1; b--) begin
      if (pend_i[b]) begin
        cause_o = cause_e'(4'(b));
        ep_o    = '0;
        kind_o  = XK_NONE;
      end
    end
  end

  // R9: a data endpoint is reported only behind all control and bus causes
  assert_data_after_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == CAUSE_DATA_EP) |-> ((pend_i[CTRL_BITS-1:1] == '0) &&
      pend_i[CTRL_BITS - 1 + int'(ep_o)] && (ep_o != '0)));

  // R10: kind agrees with the endpoint number modulo 3
  assert_kind_mod3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_o == CAUSE_DATA_EP) |->
      (int'(kind_o) == ((int'(ep_o) - 3 * (int'(ep_o) / 3)) == 0 ? 3
                        : (int'(ep_o) - 3 * (int'(ep_o) / 3)))));
endmodule

// File: rtl/usb_irq_decoder.sv
module usb_irq_decoder
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 15,
  parameter int EP_W   = 4,
  parameter int FLAG_W = CTRL_BITS + NUM_EP,
  parameter int SEL_W  = $clog2(FLAG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic              rd_clr_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  input  logic              mask_wr_i,
  input  logic [FLAG_W-1:0] mask_data_i,
  input  logic              irq_pol_hi_i,
  input  logic              ep0_irq_en_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic [3:0]        cause_o,
  output logic [EP_W-1:0]   cause_ep_o,
  output logic [1:0]        cause_xfer_o
);
  localparam logic [FLAG_W-1:0] EP0_BITS = FLAG_W'(4'b1110);

  logic [FLAG_W-1:0] flags, mask_q, pend;
  cause_e            cause;
  xfer_kind_e        kind;

  usb_irq_flags #(.FLAG_W(FLAG_W), .SEL_W(SEL_W)) flags_u (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i),
    .rd_clr_i(rd_clr_i), .rd_sel_i(rd_sel_i), .flags_o(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_data_i;
  end

  assign pend = flags & mask_q & (ep0_irq_en_i ? '1 : ~EP0_BITS);

  usb_irq_prio #(.NUM_EP(NUM_EP), .EP_W(EP_W), .FLAG_W(FLAG_W)) prio_u (
    .clk(clk), .rst_n(rst_n), .pend_i(pend),
    .cause_o(cause), .ep_o(cause_ep_o), .kind_o(kind)
  );

  assign irq_o        = (|pend) ^ ~irq_pol_hi_i;
  assign flags_o      = flags;
  assign cause_o      = cause;
  assign cause_xfer_o = kind;

  // R7: line level follows the decode under the chosen polarity
  assert_irq_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((cause != CAUSE_NONE) ^ ~irq_pol_hi_i));

  // R6: endpoint 0 causes are hidden while their enable is off
  assert_ep0_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ep0_irq_en_i |-> !(cause inside {CAUSE_SETUP, CAUSE_EP0_IN, CAUSE_EP0_OUT}));
endmodule

// File: tb/usb_irq_decoder_tb_top.sv
`timescale 1ns/1ps
module usb_irq_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] evt = '0, mdata = '0;
  logic        rclr = 1'b0, mwr = 1'b0, pol = 1'b1, e0 = 1'b1;
  logic [4:0]  rsel = '0;
  logic [22:0] flags_o;
  logic        irq_o;
  logic [3:0]  cause_o, ep_o;
  logic [1:0]  xfer_o;

  always #2.5 clk = ~clk;

  usb_irq_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_clr_i(rclr), .rd_sel_i(rsel),
    .mask_wr_i(mwr), .mask_data_i(mdata), .irq_pol_hi_i(pol), .ep0_irq_en_i(e0),
    .flags_o(flags_o), .irq_o(irq_o), .cause_o(cause_o), .cause_ep_o(ep_o),
    .cause_xfer_o(xfer_o)
  );

  typedef struct {
    logic [22:0] flags;
    logic        irq;
    logic [3:0]  cause;
    logic [3:0]  ep;
    logic [1:0]  xk;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_checks = 0, n_errs = 0;
  logic [22:0] m_flags = '0, m_mask = '0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [22:0] p;
    bit found = 0;
    p = m_flags & m_mask & (e0 ? 23'h7fffff : ~23'h00000e);
    e.flags = m_flags; e.cause = 0; e.ep = 0; e.xk = 0; e.tag = tag;
    for (int b = 1; b <= 7; b++)
      if (!found && p[b]) begin e.cause = 4'(b); found = 1; end
    for (int n = 1; n <= 15; n++)
      if (!found && p[n+7]) begin
        e.cause = 8; e.ep = 4'(n); found = 1;
        e.xk = (n % 3 == 1) ? 2'd1 : (n % 3 == 2) ? 2'd2 : 2'd3;
      end
    e.irq = (p != 0) ^ !pol;
    return e;
  endfunction

  task automatic step(input logic [22:0] ev, input logic rc, input logic [4:0] rs,
                      input logic mw, input logic [22:0] md,
                      input logic p_hi, input logic e0_en, input string tag);
    logic [22:0] clrv;
    @(negedge clk);
    evt = ev; rclr = rc; rsel = rs; mwr = mw; mdata = md; pol = p_hi; e0 = e0_en;
    clrv = (rc && rs < 23) ? (23'd1 << rs) : '0;
    m_flags = (m_flags & ~clrv) | (ev & ~23'd1);
    if (mw) m_mask = md;
    exp_q.push_back(model(tag));
    @(posedge clk);
    #2;
    evt = '0; rclr = 1'b0; mwr = 1'b0;
  endtask

  // monitor: compare outputs just after each edge a driver step covered
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(flags_o === e.flags, e.tag, "flags", flags_o, e.flags);
      chk(irq_o   === e.irq,   e.tag, "irq",   irq_o,   e.irq);
      chk(cause_o === e.cause, e.tag, "cause", cause_o, e.cause);
      chk(ep_o    === e.ep,    e.tag, "ep",    ep_o,    e.ep);
      chk(xfer_o  === e.xk,    e.tag, "kind",  xfer_o,  e.xk);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step('0, 0, 0, 0, '0, 1, 1, "R1_reset");
    step('0, 0, 0, 0, '0, 0, 1, "R1_inactive_low");
    // R11: reserved bit ignored
    step(23'd1, 0, 0, 1, 23'h7fffff, 1, 1, "R11_rsvd");
    // R2: set and hold
    step(23'd1 << 4, 0, 0, 0, '0, 1, 1, "R2_set");
    step('0, 0, 0, 0, '0, 1, 1, "R2_sticky");
    // R8: priority among control/bus
    step((23'd1 << 6) | (23'd1 << 1), 0, 0, 0, '0, 1, 1, "R8_setup_first");
    step('0, 1, 5'd1, 0, '0, 1, 1, "R3_clear_setup");
    // R4: set wins on same-cycle clear
    step(23'd1 << 4, 1, 5'd4, 0, '0, 1, 1, "R4_set_wins");
    step('0, 1, 5'd4, 0, '0, 1, 1, "R3_clear_reset");
    step('0, 1, 5'd6, 0, '0, 1, 1, "R3_clear_suspend");
    // R3: out-of-range index clears nothing
    step(23'd1 << 7, 0, 0, 0, '0, 1, 1, "R8_connect");
    step('0, 1, 5'd25, 0, '0, 1, 1, "R3_out_of_range");
    step('0, 1, 5'd7, 0, '0, 0, 1, "R7_idle_low_pol");
    // R6: ep0 gate
    step(23'd1 << 2, 0, 0, 0, '0, 1, 0, "R6_ep0_gated");
    step('0, 0, 0, 0, '0, 1, 1, "R6_ep0_open");
    step(23'd1 << 3, 0, 0, 0, '0, 1, 1, "R8_ep0_in_over_out");
    step('0, 1, 5'd2, 0, '0, 1, 1, "R8_ep0_out");
    step('0, 1, 5'd3, 0, '0, 1, 1, "R3_all_clear");
    // R9/R10: data endpoints, lowest wins, kinds
    step((23'd1 << 22) | (23'd1 << 12), 0, 0, 0, '0, 1, 1, "R9_lowest_ep5");
    step('0, 1, 5'd12, 0, '0, 1, 1, "R10_int_in_ep15");
    step(23'd1 << 11, 0, 0, 0, '0, 1, 1, "R10_bulk_out_ep4");
    step(23'd1 << 5, 0, 0, 0, '0, 1, 1, "R9_ctrl_over_data");
    step('0, 1, 5'd5, 0, '0, 0, 1, "R7_active_low");
    // R5: mask gating and reload
    step('0, 0, 0, 1, 23'h7fffff & ~(23'd1 << 11), 1, 1, "R5_mask_off_ep4");
    step(23'd1 << 9, 0, 0, 1, 23'h000000, 1, 1, "R5_all_masked");
    step('0, 0, 0, 1, 23'd1 << 9, 1, 1, "R10_bulk_in_ep2");
    step('0, 0, 0, 0, '0, 1, 1, "R5_end");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule